// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block sits in the oscillator clock domain of a frequency synthesiser that has several channels. Each channel compares a reference pulse stream with the divided feedback pulse stream from its own oscillator. It turns the timing difference into up and down commands for a charge pump. A drive-enable line tells the pad when either pump transistor should conduct. When drive-enable is low, the pump output floats at high impedance. A per-channel polarity bit swaps the up and down roles, so the same loop works with either slope of the oscillator tuning curve.

For each channel, the block measures the width of every comparison in oscillator clock cycles. The width is the number of cycles between registering the leading edge and registering the lagging edge. A channel loses lock as soon as a comparison grows to the unlock width. It regains lock only after a run of consecutive comparisons that are all narrow. A per-channel power-save input silences the pump outputs, and while it is asserted the channel counts as locked in the combined indicator. When power-save is released, the first pump pulse is cut short so that the oscillator does not receive a large correction step.

Top module: `pfd_lock`

## Requirements
- R1: With the polarity bit at 1, a reference edge that arrives before the feedback edge raises `pump_up` and leaves `pump_dn` low. A feedback edge that arrives first raises `pump_dn` and leaves `pump_up` low. Both become visible in the cycle after the edge is registered.
- R2: With the polarity bit at 0, the roles are swapped: when the reference leads, `pump_dn` is high and `pump_up` is low.
- R3: When both edges arrive in the same cycle, both pump lines are high together for exactly one cycle. This short pulse removes the dead zone. In the next cycle both pump lines are low and `drive_en` is 0, which means high impedance.
- R4: While one side's edge is pending, a further edge on that same side is ignored. The pending line stays high until the other side's edge arrives, so a phase error of up to two full cycles is tracked.
- R5: A comparison is k cycles wide when its edges are k cycles apart. The channel leaves the locked state in the cycle in which the running width reaches UNLOCK_TH (default 2), before the comparison ends.
- R6: The channel enters the locked state at the end of a comparison when that comparison and the ones before it form LOCK_RUNS (default 3) consecutive comparisons of width at most LOCK_TH (default 4), and the last one is narrower than UNLOCK_TH. With identical edges, `ld` rises one cycle after the coincident pulse.
- R7: A comparison wider than LOCK_TH clears the run of narrow comparisons, so a full new run of LOCK_RUNS is needed afterwards.
- R8: While power-save is high, the channel's `pump_up`, `pump_dn` and `drive_en` are 0 and its edges have no effect. The channel counts as locked. Its lock state is cleared, so after release it must lock again.
- R9: `ld` is 1 only when every channel is locked or in power-save.
- R10: In the first comparison after power-save is released, the pump lines are forced low once the running width reaches SOFT_LIM (default 2) cycles. Later comparisons are not limited.
- R11: After reset, no comparison is pending, all pump and drive outputs are 0, and every channel is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | NCH | Reference pulse stream per channel; a rising edge starts or ends a comparison |
| fb_in | input | NCH | Divided feedback pulse stream per channel |
| pol | input | NCH | Pump polarity per channel (1: reference leading drives up) |
| psave | input | NCH | Power-save per channel, active high |
| pump_up | output | NCH | Drive-high command for the pump |
| pump_dn | output | NCH | Drive-low command for the pump |
| drive_en | output | NCH | Pump conducting; 0 means high impedance |
| ld | output | 1 | Combined lock indicator |

## Verification
The assertions assume that the reference and feedback inputs are synchronous to the oscillator clock and that each rising edge is followed by at least one low cycle. They also assume that power-save changes between comparisons and not in the middle of a pulse. The bench meets these assumptions. It drives every input on the falling clock edge and makes each pulse exactly one cycle long. It leaves at least ten idle cycles after the lagging edge before the next comparison starts. It changes power-save only while both streams are idle.

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int NCH       = 2,
  parameter int CNT_W     = 6,
  parameter int UNLOCK_TH = 2,
  parameter int LOCK_TH   = 4,
  parameter int LOCK_RUNS = 3,
  parameter int SOFT_LIM  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ref_in,
  input  logic [NCH-1:0] fb_in,
  input  logic [NCH-1:0] pol,
  input  logic [NCH-1:0] psave,
  output logic [NCH-1:0] pump_up,
  output logic [NCH-1:0] pump_dn,
  output logic [NCH-1:0] drive_en,
  output logic           ld
);
  localparam int RUN_W = $clog2(LOCK_RUNS + 1);
  localparam logic [CNT_W-1:0] UNL  = CNT_W'(UNLOCK_TH);
  localparam logic [CNT_W-1:0] LKT  = CNT_W'(LOCK_TH);
  localparam logic [CNT_W-1:0] SLIM = CNT_W'(SOFT_LIM);
  localparam logic [RUN_W-1:0] RUNS = RUN_W'(LOCK_RUNS);

  logic [NCH-1:0] ch_ok;

  for (genvar g = 0; g < NCH; g++) begin : gen_ch
    logic             ref_d, fb_d, up_q, dn_q, lock_q, soft_q;
    logic [CNT_W-1:0] err_q;
    logic [RUN_W-1:0] run_q;

    wire ref_e = ref_in[g] & ~ref_d;
    wire fb_e  = fb_in[g] & ~fb_d;
    wire done  = up_q & dn_q;
    wire split = up_q ^ dn_q;
    wire [CNT_W-1:0] err_inc = (err_q == '1) ? err_q : err_q + 1'b1;
    wire             good    = err_q <= LKT;
    wire [RUN_W-1:0] run_nxt = !good ? '0 : (run_q == RUNS) ? run_q : run_q + 1'b1;
    wire             mask    = soft_q & (err_q >= SLIM);
    wire             act     = ~psave[g] & ~mask;
    wire             a       = up_q & act;
    wire             b       = dn_q & act;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ref_d <= 1'b0; fb_d <= 1'b0; up_q <= 1'b0; dn_q <= 1'b0;
        lock_q <= 1'b0; soft_q <= 1'b0; err_q <= '0; run_q <= '0;
      end else begin
        ref_d <= ref_in[g];
        fb_d  <= fb_in[g];
        if (psave[g]) begin
          up_q <= 1'b0; dn_q <= 1'b0; err_q <= '0; run_q <= '0;
          lock_q <= 1'b0; soft_q <= 1'b1;
        end else if (done) begin
          up_q  <= ref_e;
          dn_q  <= fb_e;
          err_q <= '0;
          run_q <= run_nxt;
          soft_q <= 1'b0;
          if (run_nxt >= RUNS && err_q < UNL) lock_q <= 1'b1;
        end else begin
          up_q <= up_q | ref_e;
          dn_q <= dn_q | fb_e;
          if (split) begin
            err_q <= err_inc;
            if (err_inc >= UNL) lock_q <= 1'b0;
          end
        end
      end
    end

    assign pump_up[g]  = pol[g] ? a : b;
    assign pump_dn[g]  = pol[g] ? b : a;
    assign drive_en[g] = a | b;
    assign ch_ok[g]    = lock_q | psave[g];

    // R3
    both_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(ref_e && fb_e)) |=> !(up_q && dn_q));
    // R4
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && !dn_q && !psave[g]) |=> up_q);
    // R5
    unlock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q >= UNL) |-> !lock_q);
    // R6
    lock_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past(done));
    // R8
    psave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psave[g] |-> (!pump_up[g] && !pump_dn[g] && !drive_en[g]));
  end

  assign ld = &ch_ok;
endmodule

// File: tb/pfd_lock_tb.sv
`timescale 1ns/1ps
module pfd_lock_tb;
  localparam int NCH = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] ref_in = '0, fb_in = '0, pol = '1, psave = 2'b10;
  logic [NCH-1:0] pump_up, pump_dn, drive_en;
  logic ld;
  int checks = 0, fails = 0;
  logic [15:0] r_up, r_dn, r_en, r_ld;

  pfd_lock u_dut (.clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .pol(pol), .psave(psave), .pump_up(pump_up), .pump_dn(pump_dn),
    .drive_en(drive_en), .ld(ld));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One comparison on channel ch; index i of the records is the state after the i-th edge.
  task automatic cmp(input int ch, input int tr, input int tf, input int tr2);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      r_up[i] = pump_up[ch]; r_dn[i] = pump_dn[ch];
      r_en[i] = drive_en[ch]; r_ld[i] = ld;
      ref_in[ch] = (i == tr) || (i == tr2);
      fb_in[ch]  = (i == tf);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 pump_up", pump_up[0], 0);
    chk("R11 pump_dn", pump_dn[0], 0);
    chk("R11 drive_en", drive_en[0], 0);
    chk("R11 ld", ld, 0);
  endtask

  task automatic t_equal();
    cmp(0, 0, 0, -1);
    chk("R3 up pulse", r_up[1], 1);
    chk("R3 dn pulse", r_dn[1], 1);
    chk("R3 drive pulse", r_en[1], 1);
    chk("R3 hiz up", r_up[2], 0);
    chk("R3 hiz dn", r_dn[2], 0);
    chk("R3 hiz drive", r_en[2], 0);
  endtask

  task automatic t_polarity();
    cmp(0, 0, 2, -1);
    chk("R1 ref lead up", r_up[2], 1);
    chk("R1 ref lead dn", r_dn[2], 0);
    chk("R1 ref lead en", r_en[1], 1);
    cmp(0, 2, 0, -1);
    chk("R1 fb lead dn", r_dn[1], 1);
    chk("R1 fb lead up", r_up[1], 0);
    pol[0] = 1'b0;
    cmp(0, 0, 2, -1);
    chk("R2 swapped up", r_up[1], 0);
    chk("R2 swapped dn", r_dn[1], 1);
    pol[0] = 1'b1;
  endtask

  task automatic t_wrap();
    cmp(0, 0, 4, 2);
    chk("R4 up kept", r_up[3], 1);
    chk("R4 up kept later", r_up[4], 1);
    chk("R4 no early dn", r_dn[4], 0);
    chk("R4 end both", r_dn[5] & r_up[5], 1);
    chk("R4 cleared", r_up[6] | r_dn[6], 0);
  endtask

  task automatic t_lock();
    cmp(0, 0, 5, -1);
    chk("R7 wide leaves unlocked", r_ld[8], 0);
    cmp(0, 0, 0, -1);
    cmp(0, 0, 0, -1);
    chk("R6 two runs not enough", r_ld[5], 0);
    cmp(0, 0, 0, -1);
    chk("R6 not before end", r_ld[1], 0);
    chk("R6 locked", r_ld[2], 1);
  endtask

  task automatic t_unlock();
    cmp(0, 0, 4, -1);
    chk("R5 still locked", r_ld[2], 1);
    chk("R5 drops at width", r_ld[3], 0);
    cmp(0, 0, 5, -1);
    cmp(0, 0, 0, -1);
    chk("R7 run cleared", r_ld[4], 0);
    cmp(0, 0, 0, -1);
    cmp(0, 0, 0, -1);
    chk("R7 relock after run", r_ld[4], 1);
  endtask

  task automatic t_psave();
    psave[0] = 1'b1;
    cmp(0, 0, 3, -1);
    chk("R8 up quiet", r_up[2], 0);
    chk("R8 drive quiet", r_en[1] | r_en[2] | r_en[4], 0);
    chk("R9 both saved ld", r_ld[6], 1);
    @(negedge clk);
    psave[0] = 1'b0;
    @(negedge clk);
    chk("R8 lock cleared", ld, 0);
  endtask

  task automatic t_soft();
    cmp(0, 0, 5, -1);
    chk("R10 first pulse", r_up[1], 1);
    chk("R10 second cycle", r_up[2], 1);
    chk("R10 cut up", r_up[3], 0);
    chk("R10 cut drive", r_en[4], 0);
    cmp(0, 0, 5, -1);
    chk("R10 later unlimited", r_up[4], 1);
  endtask

  task automatic t_combined();
    repeat (3) cmp(0, 0, 0, -1);
    chk("R9 ch0 locked ch1 saved", ld, 1);
    psave[1] = 1'b0;
    @(negedge clk);
    chk("R9 ch1 unlocked", ld, 0);
    repeat (3) cmp(1, 0, 0, -1);
    chk("R9 both locked", ld, 1);
    psave[1] = 1'b1;
    cmp(0, 0, 4, -1);
    chk("R9 ch0 unlocked", r_ld[8], 0);
  endtask

  initial begin
    t_reset();
    t_equal();
    t_polarity();
    t_wrap();
    t_lock();
    t_unlock();
    t_psave();
    t_soft();
    t_combined();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule